// File: doc/BRIEF.md
# Relocatable Peripheral Address Decoder

This block decodes I/O bus accesses for four on-chip peripherals: a DMA controller, an interrupt controller, a timer and a serial unit. Software can move their register windows at run time. A small bank of control registers sits at fixed addresses at the top of I/O space. Each peripheral has a low address byte, and all four share one high address byte. An enable register switches each window on or off. A configuration register chooses between two register layouts: registers packed at consecutive byte addresses, or registers spread on 16-bit boundaries.

For every access, the decoder returns three results, all combinational from the address and the stored registers:
- a one-hot chip-select naming the peripheral that owns the address;
- the index of the register addressed inside that peripheral;
- a flag saying whether the access is legal for that register.

The fixed region at the top of I/O space always wins over any relocated window. Overlapping windows are resolved by a fixed priority.

Top module: `perimap_decoder`

## Requirements
- R1: After reset, the high byte, the four low bytes, the enable bits and the configuration byte are all zero. As a result, no access asserts any chip-select and `sys_cfg` reads 0x00.
- R2: A bus write to a control register updates it at the clock edge that samples the write. The word at 0xFFF8 holds the serial low byte on lane 0 and the timer low byte on lane 1. The word at 0xFFFA holds the interrupt low byte on lane 0 and the DMA low byte on lane 1. The word at 0xFFFC holds the common high byte on lane 0 and the enable byte on lane 1. The word at 0xFFFE holds the configuration byte on lane 0. Lane 0 is `bus_wdata[7:0]` gated by `bus_be[0]`, and lane 1 is `bus_wdata[15:8]` gated by `bus_be[1]`.
- R3: A peripheral's base address is {common high byte, its own low byte}.
- R4: Chip-select bit 0 is DMA, bit 1 is the interrupt controller, bit 2 is the timer and bit 3 is the serial unit. Enable bit n gates chip-select bit n, and a peripheral whose enable bit is 0 is never selected.
- R5: With configuration bit 0 clear (word spacing), a window covers base to base+7. The register index is (address-base)/2, and `acc_ok` is 1 only for even offsets.
- R6: With configuration bit 0 set (byte spacing), a window covers base to base+3. The register index is address-base, and `acc_ok` is 1 for every offset.
- R7: An address at 0xFF00 or above never asserts a chip-select, even when a window reaches into that region. Such an access raises `int_hit`.
- R8: When enabled windows overlap, only the highest-priority peripheral is selected: DMA, then interrupt controller, then timer, then serial. At most one chip-select bit is ever high.
- R9: Timer register index 3 is write-only, so a read of it gives `acc_ok` = 0 while a write of it gives `acc_ok` = 1. `acc_ok` is 0 whenever no chip-select is asserted.
- R10: The access that immediately follows a control write is decoded with the new value.
- R11: While `bus_valid` is low, no chip-select and no `int_hit` are asserted.
- R12: Lane 1 of the word at 0xFFFE is ignored. A lane whose byte enable is low leaves its register unchanged. Configuration bits 7 to 1 are stored and passed out on `sys_cfg` without affecting the decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Access present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | I/O byte address |
| bus_wdata | input | 16 | Write data, two byte lanes |
| bus_be | input | 2 | Byte-lane enables |
| per_sel | output | 4 | One-hot peripheral chip-select |
| reg_idx | output | 2 | Register index inside the selected peripheral |
| acc_ok | output | 1 | Access legal for the selected register |
| int_hit | output | 1 | Access falls in the fixed internal region |
| sys_cfg | output | 8 | Stored configuration byte |

## Verification
The hardest case to create from the ports is a window that straddles the protected boundary while another window overlaps it. This needs a base near 0xFEFF and coinciding low bytes, which in turn takes a chain of lane-split control writes.

The bench programs the high byte to 0xFE and a low byte to 0xFE in byte-spacing mode. It then walks across 0xFF00. Separately, it aliases the DMA, interrupt and timer low bytes to one value, so that the priority chain is exercised level by level. Each step is decoded in the very cycle after the control write that set it up.

// File: rtl/perimap_pkg.sv
package perimap_pkg;
   localparam int NUM_PERIPH = 4;
   localparam int BYTE_W     = 8;

   typedef enum logic [1:0] {
      PER_DMA = 2'd0,
      PER_ICU = 2'd1,
      PER_TMR = 2'd2,
      PER_SER = 2'd3
   } per_id_e;

   localparam logic [1:0] WORD_LO_A = 2'd0; // serial / timer
   localparam logic [1:0] WORD_LO_B = 2'd1; // interrupt / dma
   localparam logic [1:0] WORD_HI   = 2'd2; // high byte / enable
   localparam logic [1:0] WORD_CFG  = 2'd3; // configuration
endpackage

// File: rtl/perimap_regs.sv
module perimap_regs
   import perimap_pkg::*;
#(
   parameter int          ADDR_W    = 16,
   parameter logic [15:0] CTRL_BASE = 16'hFFF8
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               wr_req,
   input  logic [ADDR_W-1:1]                  wr_word,
   input  logic [2*BYTE_W-1:0]                wdata,
   input  logic [1:0]                         be,
   output logic [NUM_PERIPH-1:0][BYTE_W-1:0]  low_q,
   output logic [BYTE_W-1:0]                  hi_q,
   output logic [NUM_PERIPH-1:0]              en_q,
   output logic [BYTE_W-1:0]                  cfg_q
);
   localparam int TAG_LSB = 3;

   logic in_ctrl;
   logic [1:0] word_sel;
   logic [BYTE_W-1:0] lane0, lane1;

   assign in_ctrl  = wr_req && (wr_word[ADDR_W-1:TAG_LSB] == CTRL_BASE[ADDR_W-1:TAG_LSB]);
   assign word_sel = wr_word[TAG_LSB-1:1];
   assign lane0    = wdata[BYTE_W-1:0];
   assign lane1    = wdata[2*BYTE_W-1:BYTE_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_q <= '0;
         hi_q  <= '0;
         en_q  <= '0;
         cfg_q <= '0;
      end else if (in_ctrl) begin
         unique case (word_sel)
            WORD_LO_A: begin
               if (be[0]) low_q[PER_SER] <= lane0;
               if (be[1]) low_q[PER_TMR] <= lane1;
            end
            WORD_LO_B: begin
               if (be[0]) low_q[PER_ICU] <= lane0;
               if (be[1]) low_q[PER_DMA] <= lane1;
            end
            WORD_HI: begin
               if (be[0]) hi_q <= lane0;
               if (be[1]) en_q <= lane1[NUM_PERIPH-1:0];
            end
            default: begin
               if (be[0]) cfg_q <= lane0;
            end
         endcase
      end
   end

   // R2: enable lane write is visible after the edge
   assert_enable_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ctrl && word_sel == WORD_HI && be[1]) |=> (en_q == $past(lane1[NUM_PERIPH-1:0])));

   // R12: high lane of the configuration word never alters the configuration
   assert_cfg_hi_lane_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ctrl && word_sel == WORD_CFG && !be[0]) |=> $stable(cfg_q));
endmodule

// File: rtl/perimap_window.sv
module perimap_window #(
   parameter int ADDR_W   = 16,
   parameter int NUM_REGS = 4,
   localparam int IDX_W   = $clog2(NUM_REGS)
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] base,
   input  logic              enable,
   input  logic              byte_mode,
   output logic              hit,
   output logic [IDX_W-1:0]  idx,
   output logic              lane_ok
);
   localparam logic [ADDR_W-1:0] SPAN_BYTE = ADDR_W'(NUM_REGS);
   localparam logic [ADDR_W-1:0] SPAN_WORD = ADDR_W'(2 * NUM_REGS);

   logic [ADDR_W:0]   off;
   logic [ADDR_W-1:0] span;
   logic              below;

   assign off   = {1'b0, addr} - {1'b0, base};
   assign below = off[ADDR_W];
   assign span  = byte_mode ? SPAN_BYTE : SPAN_WORD;
   assign hit   = enable && !below && (off[ADDR_W-1:0] < span);

   generate
      if (IDX_W + 1 <= ADDR_W) begin : g_idx
         assign idx = byte_mode ? off[IDX_W-1:0] : off[IDX_W:1];
      end else begin : g_bad_idx
         $error("register index wider than address");
      end
   endgenerate

   assign lane_ok = byte_mode || !off[0];
endmodule

// File: rtl/perimap_arbiter.sv
module perimap_arbiter
   import perimap_pkg::*;
#(
   parameter int IDX_W = 2
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [NUM_PERIPH-1:0]            hit,
   input  logic [NUM_PERIPH-1:0][IDX_W-1:0] idx_in,
   input  logic [NUM_PERIPH-1:0]            lane_in,
   output logic [NUM_PERIPH-1:0]            grant,
   output logic [IDX_W-1:0]                 idx_out,
   output logic                             lane_out
);
   logic [NUM_PERIPH:0] taken;
   assign taken[0] = 1'b0;

   generate
      for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_chain
         assign grant[i]   = hit[i] && !taken[i];
         assign taken[i+1] = taken[i] || hit[i];
      end
   endgenerate

   always_comb begin
      idx_out  = '0;
      lane_out = 1'b0;
      for (int i = 0; i < NUM_PERIPH; i++) begin
         if (grant[i]) begin
            idx_out  = idx_in[i];
            lane_out = lane_in[i];
         end
      end
   end

   // R8: a grant only goes to a requesting window
   assert_grant_subset_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & ~hit) == '0);
endmodule

// File: rtl/perimap_decoder.sv
module perimap_decoder
   import perimap_pkg::*;
#(
   parameter int          ADDR_W     = 16,
   parameter int          NUM_REGS   = 4,
   parameter logic [15:0] FIXED_BASE = 16'hFF00,
   parameter logic [15:0] CTRL_BASE  = 16'hFFF8,
   localparam int         IDX_W      = $clog2(NUM_REGS),
   localparam int         WO_IDX     = NUM_REGS - 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_valid,
   input  logic                  bus_write,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [2*BYTE_W-1:0]   bus_wdata,
   input  logic [1:0]            bus_be,
   output logic [NUM_PERIPH-1:0] per_sel,
   output logic [IDX_W-1:0]      reg_idx,
   output logic                  acc_ok,
   output logic                  int_hit,
   output logic [BYTE_W-1:0]     sys_cfg
);
   generate
      if (ADDR_W != 2 * BYTE_W) begin : g_bad_addr
         $error("address must be two bytes wide");
      end
      if (NUM_REGS < 2 || (1 << IDX_W) != NUM_REGS) begin : g_bad_regs
         $error("register count must be a power of two, at least 2");
      end
      if (CTRL_BASE < FIXED_BASE) begin : g_bad_ctrl
         $error("control registers must lie inside the fixed region");
      end
   endgenerate

   logic [NUM_PERIPH-1:0][BYTE_W-1:0] low_q;
   logic [BYTE_W-1:0]                 hi_q;
   logic [NUM_PERIPH-1:0]             en_q;
   logic [BYTE_W-1:0]                 cfg_q;
   logic                              in_fixed;
   logic                              byte_mode;

   perimap_regs #(.ADDR_W(ADDR_W), .CTRL_BASE(CTRL_BASE)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_req  (bus_valid && bus_write),
      .wr_word (bus_addr[ADDR_W-1:1]),
      .wdata   (bus_wdata),
      .be      (bus_be),
      .low_q   (low_q),
      .hi_q    (hi_q),
      .en_q    (en_q),
      .cfg_q   (cfg_q)
   );

   assign in_fixed  = bus_addr >= ADDR_W'(FIXED_BASE);
   assign byte_mode = cfg_q[0];

   logic [NUM_PERIPH-1:0]            win_hit;
   logic [NUM_PERIPH-1:0][IDX_W-1:0] win_idx;
   logic [NUM_PERIPH-1:0]            win_lane;

   generate
      for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_win
         perimap_window #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_win (
            .addr      (bus_addr),
            .base      ({hi_q, low_q[p]}),
            .enable    (en_q[p] && bus_valid && !in_fixed),
            .byte_mode (byte_mode),
            .hit       (win_hit[p]),
            .idx       (win_idx[p]),
            .lane_ok   (win_lane[p])
         );
      end
   endgenerate

   logic lane_sel;

   perimap_arbiter #(.IDX_W(IDX_W)) u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit      (win_hit),
      .idx_in   (win_idx),
      .lane_in  (win_lane),
      .grant    (per_sel),
      .idx_out  (reg_idx),
      .lane_out (lane_sel)
   );

   logic wo_read;
   assign wo_read = per_sel[PER_TMR] && (reg_idx == IDX_W'(WO_IDX)) && !bus_write;
   assign acc_ok  = lane_sel && !wo_read;
   assign int_hit = bus_valid && in_fixed;
   assign sys_cfg = cfg_q;

   // R8: never more than one chip-select
   assert_onehot_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(per_sel));

   // R7: fixed region is never overlaid
   assert_fixed_region_R7: assert property (@(posedge clk) disable iff (!rst_n)
      int_hit |-> (per_sel == '0));

   // R4: a disabled peripheral is never selected
   assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (per_sel & ~en_q) == '0);

   // R11: idle bus produces no select
   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_valid |-> (per_sel == '0 && !int_hit));

   // R9: no legal access without a select
   assert_ok_needs_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
      acc_ok |-> (per_sel != '0));
endmodule

// File: tb/test_perimap_decoder.sv
`timescale 1ns/1ps
module test_perimap_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [1:0]  bus_be = '0;
   logic [3:0]  per_sel;
   logic [1:0]  reg_idx;
   logic        acc_ok;
   logic        int_hit;
   logic [7:0]  sys_cfg;

   always #2 clk = ~clk;

   perimap_decoder i_perimap_decoder (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
      .per_sel(per_sel), .reg_idx(reg_idx), .acc_ok(acc_ok),
      .int_hit(int_hit), .sys_cfg(sys_cfg)
   );

   typedef struct {
      logic [3:0] sel;
      logic [1:0] idx;
      logic       ok;
      logic       hit;
      logic [7:0] cfg;
      string      tag;
   } exp_t;

   exp_t q[$];
   int   n_run = 0;
   int   n_fail = 0;
   bit   done = 1'b0;

   // bench model of the control registers (indices: 0 dma,1 icu,2 tmr,3 ser)
   logic [7:0] m_lo[4];
   logic [7:0] m_hi, m_cfg;
   logic [3:0] m_en;

   function automatic exp_t model(logic [15:0] a, bit w, bit v, string tag);
      exp_t e;
      e.sel = '0; e.idx = '0; e.ok = 1'b0; e.cfg = m_cfg; e.tag = tag;
      e.hit = v && (a >= 16'hFF00);
      if (v && a < 16'hFF00) begin
         for (int p = 0; p < 4; p++) begin
            int base, off, span;
            base = {m_hi, m_lo[p]};
            off  = int'(a) - base;
            span = m_cfg[0] ? 4 : 8;
            if (e.sel == '0 && m_en[p] && off >= 0 && off < span) begin
               e.sel = 4'(1 << p);
               e.idx = m_cfg[0] ? 2'(off) : 2'(off / 2);
               e.ok  = (m_cfg[0] || (off % 2 == 0)) && !(p == 2 && e.idx == 2'd3 && !w);
            end
         end
      end
      return e;
   endfunction

   task automatic acc(input logic [15:0] a, input bit w, input logic [15:0] d,
                      input logic [1:0] be, input bit v, input string tag);
      @(negedge clk);
      bus_addr = a; bus_write = w; bus_wdata = d; bus_be = be; bus_valid = v;
      q.push_back(model(a, w, v, tag));
      if (v && w && a[15:3] == 13'h1FFF) begin
         case (a[2:1])
            2'd0: begin if (be[0]) m_lo[3] = d[7:0]; if (be[1]) m_lo[2] = d[15:8]; end
            2'd1: begin if (be[0]) m_lo[1] = d[7:0]; if (be[1]) m_lo[0] = d[15:8]; end
            2'd2: begin if (be[0]) m_hi = d[7:0];    if (be[1]) m_en = d[11:8]; end
            default: begin if (be[0]) m_cfg = d[7:0]; end
         endcase
      end
   endtask

   task automatic rd(input logic [15:0] a, input string tag);
      acc(a, 1'b0, 16'h0, 2'b00, 1'b1, tag);
   endtask

   task automatic wr(input logic [15:0] a, input logic [15:0] d, input logic [1:0] be, input string tag);
      acc(a, 1'b1, d, be, 1'b1, tag);
   endtask

   // monitor: compares each cycle's outputs against the queued expectation
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_run++;
            if (per_sel !== e.sel || int_hit !== e.hit || sys_cfg !== e.cfg ||
                (e.sel != '0 && reg_idx !== e.idx) || acc_ok !== e.ok) begin
               n_fail++;
               $display("FAIL %s: sel=%b idx=%0d ok=%b hit=%b cfg=%h expected sel=%b idx=%0d ok=%b hit=%b cfg=%h",
                        e.tag, per_sel, reg_idx, acc_ok, int_hit, sys_cfg,
                        e.sel, e.idx, e.ok, e.hit, e.cfg);
            end
         end
      end
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 4; i++) m_lo[i] = '0;
      m_hi = '0; m_en = '0; m_cfg = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state, nothing decodes
      rd(16'h0000, "R1 reset base 0");
      rd(16'h0004, "R1 reset base 0 offset 4");

      // R2/R3/R10: program map hi=0x12, dma 00, icu 10, tmr 20, ser 30, all on
      wr(16'hFFFC, 16'h0F12, 2'b01, "R2 hi byte write");
      rd(16'h1220, "R10 hi written, enables still off");
      wr(16'hFFF8, 16'h2030, 2'b11, "R2 ser/tmr low");
      wr(16'hFFFA, 16'h0010, 2'b11, "R2 icu/dma low");
      wr(16'hFFFC, 16'h0F12, 2'b10, "R2 enable write");
      rd(16'h1200, "R10 R3 dma base after enable");
      rd(16'h1210, "R3 icu base");
      rd(16'h1230, "R3 serial base");

      // R5: word spacing walk of the timer window
      for (int k = 0; k < 9; k++) rd(16'h1220 + 16'(k), "R5 word spacing timer walk");
      rd(16'h121F, "R5 below timer base");

      // R9: write-only timer mode register
      rd(16'h1226, "R9 read of write-only");
      wr(16'h1226, 16'h0, 2'b01, "R9 write of write-only");
      rd(16'h1224, "R9 read of counter 2");

      // R4: disable dma
      wr(16'hFFFC, 16'h0E00, 2'b10, "R4 clear dma enable");
      rd(16'h1200, "R4 dma disabled");
      rd(16'h1211, "R4 icu still on");

      // R6/R12: byte spacing plus passthrough flags
      wr(16'hFFFE, 16'h0091, 2'b01, "R6 set byte mode");
      for (int k = 0; k < 5; k++) rd(16'h1220 + 16'(k), "R6 byte spacing timer walk");
      rd(16'h1223, "R9 byte-mode read of write-only");
      wr(16'hFFFE, 16'hAA54, 2'b10, "R12 high lane of config ignored");
      rd(16'h1221, "R12 config unchanged");
      wr(16'hFFFC, 16'h0034, 2'b00, "R12 no lanes enabled");
      rd(16'h1222, "R12 map unchanged");

      // R8: overlap priority
      wr(16'hFFFC, 16'h0F12, 2'b10, "R8 enable all");
      wr(16'hFFFA, 16'h3320, 2'b01, "R8 icu onto timer");
      rd(16'h1221, "R8 icu beats timer");
      wr(16'hFFFA, 16'h2020, 2'b10, "R8 dma onto timer");
      rd(16'h1222, "R8 dma beats icu and timer");
      wr(16'hFFF8, 16'h0021, 2'b01, "R8 serial onto timer+1");
      rd(16'h1224, "R8 serial alone past others");
      rd(16'h1223, "R8 dma over serial");

      // R7: window straddling the fixed region
      wr(16'hFFFC, 16'h08FE, 2'b11, "R7 hi FE, serial only");
      wr(16'hFFF8, 16'h00FE, 2'b01, "R7 serial low FE");
      rd(16'hFEFE, "R7 serial below boundary");
      rd(16'hFEFF, "R7 serial last byte");
      rd(16'hFF00, "R7 boundary protected");
      rd(16'hFF01, "R7 inside fixed region");
      rd(16'hFFF0, "R7 fixed region read");

      // R11: idle bus
      acc(16'hFEFE, 1'b0, 16'h0, 2'b00, 1'b0, "R11 valid low in window");
      acc(16'hFF10, 1'b0, 16'h0, 2'b00, 1'b0, "R11 valid low fixed");
      acc(16'hFFFC, 1'b1, 16'h0F00, 2'b11, 1'b0, "R11 idle write ignored");
      rd(16'hFEFE, "R11 map unchanged after idle write");

      // R2 back to word mode: config write via lane 0
      wr(16'hFFFE, 16'h0000, 2'b01, "R2 back to word spacing");
      rd(16'hFF02, "R7 word window past boundary");
      rd(16'hFEFE, "R5 word mode serial base");

      repeat (4) @(negedge clk);
      done = 1'b1;
      if (q.size() != 0) begin
         n_run++; n_fail++;
         $display("FAIL scoreboard: %0d items left, expected 0", q.size());
      end
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule